// File: doc/BRIEF.md
# NAND Sector Hamming ECC Generator and Checker

This block sits beside a flash data path and watches each byte that moves through it. It builds a single-error-correcting parity code for every 256-byte chunk. A sector is made of one or two chunks, so a 512-byte sector gives two codes. Each code holds two 11-bit words: a parity word and a companion word that covers the complementary index sets. The two words are packed into three bytes. Software or a sequencer clears the accumulators with a pulse before it streams each sector. When the stream is done, the computed codes are on `code_out`, ready to be stored in the spare area.

On a read, the same byte stream rebuilds the codes. A check is then started with the codes that were stored. The check unit registers both sets of codes and forms a syndrome for each chunk. It reports one of four results for each chunk: no error, a corrupt stored code, a correctable single-bit data error, or an uncorrectable error. For a correctable error it gives the byte and bit location. It also gives a sector-level flag for failure. The failing location is only reported; the data is not repaired.

Top module: `hamming_sector_ecc`

## Requirements
- R1: Bytes are counted from the last clear. In-sector bytes 0..255 feed chunk 0, whose code is `code_out[23:0]`. Bytes 256..511 feed chunk 1, whose code is `code_out[47:24]`. A byte is taken only in a cycle with `din_valid` high.
- R2: Each code is laid out as follows. Bits 10:0 hold the parity word P and bits 21:11 hold the companion word C. Bits 23:22 are zero, and byte 0 of the code is bits 7:0. For every set data bit at byte b and bit i of a chunk, let n = {b, i} (11 bits). P is the XOR of n over all such bits, and C is the XOR of ~n over all such bits.
- R3: `acc_clear` sets all codes to zero on the next edge and restarts the byte count at 0. A byte offered in the same cycle as `acc_clear` is dropped.
- R4: After a full sector has been taken, further bytes are ignored until the next clear. The codes stay unchanged.
- R5: `res_valid` is high for exactly the one cycle after a cycle with `chk_start` high. The results stay unchanged until the next check. The status of chunk h is `res_status[2h+1:2h]`, encoded as 00 clean, 01 code error, 10 corrected, 11 uncorrectable.
- R6: The syndrome is computed ^ stored over all 24 bits. The status is clean when the syndrome is zero, or when the computed code or the stored code is all zero.
- R7: When exactly one syndrome bit is set, the status is code error.
- R8: When exactly 11 syndrome bits are set and syndrome[10:0] ^ syndrome[21:11] equals 0x7FF, the status is corrected. In that case `res_byte` for the chunk is syndrome[10:3] and `res_bit` is syndrome[2:0]. In every other case both are zero.
- R9: Any other non-clean syndrome gives the status uncorrectable.
- R10: `res_bad` is high when any chunk reports code error or uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_clear | input | 1 | Clears the accumulators and the byte count before a sector |
| din_valid | input | 1 | A data byte is present this cycle |
| din | input | 8 | Data byte |
| code_out | output | 48 | Computed codes; chunk h occupies bits 24h+23:24h |
| chk_start | input | 1 | Starts a check against `chk_stored` |
| chk_stored | input | 48 | Stored codes, laid out like `code_out` |
| res_valid | output | 1 | One-cycle pulse when the check result is ready |
| res_status | output | 4 | Status for each chunk, 2 bits per chunk |
| res_byte | output | 16 | Failing byte offset for each chunk, 8 bits per chunk |
| res_bit | output | 6 | Failing bit index for each chunk, 3 bits per chunk |
| res_bad | output | 1 | At least one chunk has a code error or is uncorrectable |

## Verification
The bench builds the block with its default parameters: 8 byte-index bits and two chunks per sector. These defaults bring the second-chunk routing within reach, along with the OR that combines the two halves into `res_bad`. With that setup the bench can mix a clean chunk and a faulty chunk in one sector. Reference codes are built bit by bit from the stored sector image. Stored codes are then derived from flipped data bits or flipped code bits, so that every status is produced in either half. A full sector plus extra bytes exercises the count limit. A clear that arrives together with a byte exercises the restart of the count.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
   typedef enum logic [1:0] {
      ECC_CLEAN    = 2'b00,
      ECC_CODE_ERR = 2'b01,
      ECC_FIXED    = 2'b10,
      ECC_FATAL    = 2'b11
   } ecc_status_e;
endpackage

// File: rtl/ecc_chunk_acc.sv
// Byte-serial parity accumulator for one chunk: parity word and companion word.
module ecc_chunk_acc #(
   parameter int IDX_W = 8,
   localparam int PW = IDX_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [IDX_W-1:0] byte_idx,
   input  logic [7:0]       din,
   output logic [PW-1:0]    par_lo,
   output logic [PW-1:0]    par_hi
);
   logic [PW-1:0] nxt_lo, nxt_hi;
   logic [7:0]    colm;
   logic          row;

   always_comb begin
      nxt_lo = par_lo;
      nxt_hi = par_hi;
      row    = ^din;
      colm   = '0;
      // column parities: bit-index sets inside the byte
      for (int k = 0; k < 3; k++) begin
         for (int b = 0; b < 8; b++) colm[b] = ((b >> k) & 1) != 0;
         nxt_lo[k] = nxt_lo[k] ^ (^(din & colm));
         nxt_hi[k] = nxt_hi[k] ^ (^(din & ~colm));
      end
      // row parities: byte-index sets
      for (int j = 0; j < IDX_W; j++) begin
         if (byte_idx[j]) nxt_lo[3+j] = nxt_lo[3+j] ^ row;
         else             nxt_hi[3+j] = nxt_hi[3+j] ^ row;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_lo <= '0;
         par_hi <= '0;
      end else if (clear) begin
         par_lo <= '0;
         par_hi <= '0;
      end else if (en) begin
         par_lo <= nxt_lo;
         par_hi <= nxt_hi;
      end
   end
endmodule

// File: rtl/ecc_syndrome_eval.sv
// Classifies the syndrome of one chunk and extracts the failing location.
module ecc_syndrome_eval
   import nand_ecc_pkg::*;
#(
   parameter int PW = 11,
   parameter int CODE_W = 24
) (
   input  logic [CODE_W-1:0] calc,
   input  logic [CODE_W-1:0] stored,
   output ecc_status_e       status,
   output logic [PW-4:0]     byte_loc,
   output logic [2:0]        bit_loc
);
   logic [CODE_W-1:0] syn;
   logic [PW-1:0]     fold;
   int unsigned       ones;

   always_comb begin
      syn      = calc ^ stored;
      ones     = $countones(syn);
      fold     = syn[PW-1:0] ^ syn[2*PW-1:PW];
      status   = ECC_CLEAN;
      byte_loc = '0;
      bit_loc  = '0;
      if (syn == '0 || calc == '0 || stored == '0) begin
         status = ECC_CLEAN;
      end else if (ones == 1) begin
         status = ECC_CODE_ERR;
      end else if (ones == PW && fold == '1) begin
         status   = ECC_FIXED;
         byte_loc = syn[PW-1:3];
         bit_loc  = syn[2:0];
      end else begin
         status = ECC_FATAL;
      end
   end
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int CHUNKS = 2,
   localparam int PW          = IDX_W + 3,
   localparam int CODE_BYTES  = (2*PW + 7) / 8,
   localparam int CODE_W      = CODE_BYTES * 8,
   localparam int CHUNK_BYTES = 1 << IDX_W,
   localparam int TOTAL       = CHUNKS * CHUNK_BYTES,
   localparam int CNT_W       = $clog2(TOTAL + 1),
   localparam int SEL_W       = CNT_W - IDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_clear,
   input  logic                     din_valid,
   input  logic [7:0]               din,
   output logic [CHUNKS*CODE_W-1:0] code_out,
   input  logic                     chk_start,
   input  logic [CHUNKS*CODE_W-1:0] chk_stored,
   output logic                     res_valid,
   output logic [CHUNKS*2-1:0]      res_status,
   output logic [CHUNKS*IDX_W-1:0]  res_byte,
   output logic [CHUNKS*3-1:0]      res_bit,
   output logic                     res_bad
);
   if (CHUNKS < 1 || CHUNKS > 2) begin : g_bad_chunks
      $error("CHUNKS must be 1 or 2");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("IDX_W out of range");
   end

   logic [CNT_W-1:0]         cnt;
   logic                     full, take;
   logic [SEL_W-1:0]         chunk_sel;
   logic [CHUNKS*CODE_W-1:0] calc_q, stored_q;
   logic                     valid_q;

   assign full      = (cnt == CNT_W'(TOTAL));
   assign take      = din_valid && !full && !acc_clear;
   assign chunk_sel = cnt[CNT_W-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (acc_clear) cnt <= '0;
      else if (take)      cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         calc_q   <= '0;
         stored_q <= '0;
      end else begin
         valid_q <= chk_start;
         if (chk_start) begin
            calc_q   <= code_out;
            stored_q <= chk_stored;
         end
      end
   end
   assign res_valid = valid_q;

   for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
      logic [PW-1:0]     lo, hi;
      ecc_status_e       st;
      logic [CODE_W-1:0] syn_chk;

      ecc_chunk_acc #(.IDX_W(IDX_W)) i_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (acc_clear),
         .en       (take && (chunk_sel == SEL_W'(g))),
         .byte_idx (cnt[IDX_W-1:0]),
         .din      (din),
         .par_lo   (lo),
         .par_hi   (hi)
      );
      assign code_out[g*CODE_W +: CODE_W] = CODE_W'({hi, lo});

      ecc_syndrome_eval #(.PW(PW), .CODE_W(CODE_W)) i_eval (
         .calc     (calc_q[g*CODE_W +: CODE_W]),
         .stored   (stored_q[g*CODE_W +: CODE_W]),
         .status   (st),
         .byte_loc (res_byte[g*IDX_W +: IDX_W]),
         .bit_loc  (res_bit[g*3 +: 3])
      );
      assign res_status[g*2 +: 2] = st;
      assign syn_chk = calc_q[g*CODE_W +: CODE_W] ^ stored_q[g*CODE_W +: CODE_W];

      p_code_err_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && st == ECC_CODE_ERR) |-> $countones(syn_chk) == 1);
      p_fixed_weight_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && st == ECC_FIXED) |-> $countones(syn_chk) == PW);
      p_equal_is_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && syn_chk == '0) |-> st == ECC_CLEAN);
   end

   always_comb begin
      res_bad = 1'b0;
      for (int h = 0; h < CHUNKS; h++) res_bad = res_bad | res_status[2*h];
   end

   p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clear |=> code_out == '0);
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(TOTAL));
   p_hold_after_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !acc_clear) |=> $stable(code_out));
   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !chk_start) |=> !res_valid);
endmodule

// File: tb/test_hamming_sector_ecc.sv
module test_hamming_sector_ecc;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_clear = 1'b0;
   logic        din_valid = 1'b0;
   logic [7:0]  din = '0;
   logic [47:0] code_out;
   logic        chk_start = 1'b0;
   logic [47:0] chk_stored = '0;
   logic        res_valid;
   logic [3:0]  res_status;
   logic [15:0] res_byte;
   logic [5:0]  res_bit;
   logic        res_bad;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] mem [512];

   always #(CLK_PERIOD/2) clk = ~clk;

   hamming_sector_ecc i_hamming_sector_ecc (
      .clk(clk), .rst_n(rst_n), .acc_clear(acc_clear), .din_valid(din_valid),
      .din(din), .code_out(code_out), .chk_start(chk_start),
      .chk_stored(chk_stored), .res_valid(res_valid), .res_status(res_status),
      .res_byte(res_byte), .res_bit(res_bit), .res_bad(res_bad));

   function automatic logic [23:0] ref_code(input int base);
      logic [10:0] p = '0, c = '0;
      for (int b = 0; b < 256; b++)
         for (int i = 0; i < 8; i++)
            if (mem[base+b][i]) begin
               p = p ^ 11'(b*8 + i);
               c = c ^ ~11'(b*8 + i);
            end
      return {2'b00, c, p};
   endfunction

   function automatic logic [12:0] ref_eval(input logic [23:0] calc, input logic [23:0] st);
      logic [23:0] s = calc ^ st;
      if (s == 0 || calc == 0 || st == 0) return {2'b00, 11'd0};
      if ($countones(s) == 1) return {2'b01, 11'd0};
      if ($countones(s) == 11 && (s[10:0] ^ s[21:11]) == 11'h7FF) return {2'b10, s[10:0]};
      return {2'b11, 11'd0};
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic clear_acc();
      @(negedge clk); acc_clear = 1'b1;
      @(negedge clk); acc_clear = 1'b0;
   endtask

   task automatic stream(input int first, input int count, input bit gaps);
      for (int k = first; k < first + count; k++) begin
         @(negedge clk);
         if (gaps && ($urandom % 4 == 0)) begin
            din_valid = 1'b0;
            @(negedge clk);
         end
         din_valid = 1'b1;
         din = mem[k];
      end
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic run_check(input string req, input logic [23:0] c0, input logic [23:0] c1,
                            input logic [23:0] s0, input logic [23:0] s1);
      logic [12:0] e0, e1;
      e0 = ref_eval(c0, s0);
      e1 = ref_eval(c1, s1);
      @(negedge clk); chk_start = 1'b1; chk_stored = {s1, s0};
      @(negedge clk); chk_start = 1'b0;
      check({req, " R5 valid"}, 64'(res_valid), 64'd1);
      check({req, " status"}, 64'(res_status), 64'({e1[12:11], e0[12:11]}));
      check({req, " R8 byte"}, 64'(res_byte), 64'({e1[10:3], e0[10:3]}));
      check({req, " R8 bit"}, 64'(res_bit), 64'({e1[2:0], e0[2:0]}));
      check({req, " R10 bad"}, 64'(res_bad), 64'(e0[11] | e1[11]));
      @(negedge clk);
      check({req, " R5 pulse"}, 64'(res_valid), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got hung expected finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] c0, c1, f0, f1;
      int b, i, b2, i2;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check("R3 reset code", 64'(code_out), 64'd0);
      check("R5 reset valid", 64'(res_valid), 64'd0);
      check("R10 reset bad", 64'(res_bad), 64'd0);
      rst_n = 1'b1;

      // directed: a single set bit at byte 5 bit 4
      for (int k = 0; k < 512; k++) mem[k] = 8'h00;
      mem[5] = 8'h10;
      clear_acc();
      stream(0, 512, 1'b0);
      check("R2 single bit code", 64'(code_out[23:0]), 64'h3E982C);
      check("R1 chunk1 untouched", 64'(code_out[47:24]), 64'd0);

      for (int it = 0; it < 6; it++) begin
         for (int k = 0; k < 512; k++) mem[k] = 8'($urandom);
         clear_acc();
         stream(0, 512, 1'b1);
         c0 = ref_code(0); c1 = ref_code(256);
         check("R1 R2 code0", 64'(code_out[23:0]), 64'(c0));
         check("R1 R2 code1", 64'(code_out[47:24]), 64'(c1));
         run_check("R6 equal", c0, c1, c0, c1);
         run_check("R7 code bit", c0, c1, c0 ^ (24'd1 << ($urandom % 22)), c1);
         // one data bit flipped in a random half
         b = $urandom % 256; i = $urandom % 8;
         if (it % 2 == 0) begin
            mem[b][i] = ~mem[b][i]; f0 = ref_code(0); mem[b][i] = ~mem[b][i];
            run_check("R8 fix half0", c0, c1, f0, c1);
            check("R8 loc0", 64'({res_byte[7:0], res_bit[2:0]}), 64'({b[7:0], i[2:0]}));
         end else begin
            mem[256+b][i] = ~mem[256+b][i]; f1 = ref_code(256); mem[256+b][i] = ~mem[256+b][i];
            run_check("R8 fix half1", c0, c1, c0, f1);
            check("R8 loc1", 64'({res_byte[15:8], res_bit[5:3]}), 64'({b[7:0], i[2:0]}));
         end
         // two data bits flipped in half 1
         b2 = (b + 1 + $urandom % 200) % 256; i2 = $urandom % 8;
         mem[256+b][i] = ~mem[256+b][i]; mem[256+b2][i2] = ~mem[256+b2][i2];
         f1 = ref_code(256);
         mem[256+b][i] = ~mem[256+b][i]; mem[256+b2][i2] = ~mem[256+b2][i2];
         run_check("R9 double", c0, c1, c0, f1);
         check("R9 status", 64'(res_status[3:2]), 64'd3);
      end

      // zero stored code counts as clean
      run_check("R6 zero stored", c0, c1, 24'd0, c1);
      check("R6 zero status", 64'(res_status[1:0]), 64'd0);

      // bytes past the sector end are ignored
      for (int k = 0; k < 4; k++) mem[k] = 8'hA5;
      stream(0, 4, 1'b0);
      check("R4 code0 held", 64'(code_out[23:0]), 64'(c0));
      check("R4 code1 held", 64'(code_out[47:24]), 64'(c1));

      // clear together with a byte: byte dropped, count restarts
      @(negedge clk); acc_clear = 1'b1; din_valid = 1'b1; din = 8'hFE;
      @(negedge clk); acc_clear = 1'b0; din_valid = 1'b0;
      check("R3 cleared", 64'(code_out), 64'd0);
      for (int k = 0; k < 512; k++) mem[k] = 8'($urandom);
      stream(0, 512, 1'b1);
      check("R3 restart code0", 64'(code_out[23:0]), 64'(ref_code(0)));
      check("R3 restart code1", 64'(code_out[47:24]), 64'(ref_code(256)));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule